// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the bus side of a small 8-bit processor whose low address byte and data byte share one set of pins. A core hands it one request at a time: a cycle kind, a 16-bit address and, for writes, a data byte. The block then steps through a sequence of T-states. It puts the high address byte on its own pins for the whole cycle. During the first T-state it shows the low address byte on the shared lines, marked by an address strobe. It then turns the shared lines around for data and pulses the read or write strobe. It returns a done pulse, and read data where the cycle reads.

The input clock is the oscillator, and one T-state lasts two of its periods. A slow target can stretch a cycle by holding its ready input low. Another bus master can ask for the bus with a request line. The block hands the bus over only between cycles: it floats its address, shared-line and control outputs and raises a grant.

The request side is a valid/ready port. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The caller must hold the kind, address and data stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only in the second oscillator clock of an idle T-state. The response has no back-pressure. `rsp_valid` is a single-clock pulse, and the caller must take `rsp_rdata` while it is high.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are held as follows: the address strobe is low, `read_n` and `write_n` are high, `ad_oe` is low, `bus_grant` is low and `rsp_valid` is low.
- R2: Every T-state lasts exactly two clock periods. In idle, `req_ready` is high on every second clock and low on the clocks between.
- R3: The address strobe is high exactly during T1, which is the first two clocks after the accepting edge. During T1, `ad_oe` is high and `ad_out` carries address bits 7:0. `addr_hi` carries address bits 15:8 with `addr_oe` high for the whole cycle.
- R4: Without wait states, an opcode fetch (kind 0) lasts 4 T-states. Every other kind lasts 3 T-states.
- R5: In read kinds (0, 1, 3, and 5 to 7), `ad_oe` drops after T1. `read_n` is low for T2 and any wait T-states, and high again in T3. The shared lines are sampled at the end of the last T-state in which `read_n` is low.
- R6: In write kinds (2 and 4), `write_n` is low for T2 and any wait T-states. `ad_oe` stays high and `ad_out` holds the write data from T2 through T3. The strobe that does not belong to the cycle kind never goes low.
- R7: During a cycle, `io_sel` is 1 for I/O kinds (3, 4) and 0 for all others. `cyc_stat[1:0]` is 2'b11 for an opcode fetch, 2'b10 for a read and 2'b01 for a write. Kinds 5 to 7 behave exactly as a memory read (kind 1).
- R8: `slave_rdy` is sampled at the end of T2 and of each wait T-state. If it is low there, one more wait T-state follows, with the strobes and status unchanged.
- R9: `bus_req` is granted only from an idle T-state, never in the middle of a cycle. While granted, `bus_grant` is high and `addr_oe`, `ad_oe` and `ctl_oe` are low. After `bus_req` drops, `bus_grant` falls and the outputs are driven again.
- R10: `rsp_valid` pulses for one clock, on the second clock of the cycle's final T-state. For a read, `rsp_rdata` then holds the sampled byte.
- R11: No request is accepted while `bus_req` is high in idle or while the bus is granted. `req_ready` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, two periods per T-state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken on this edge |
| req_kind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write, 5-7 as 1 |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_rdata | output | 8 | Byte read by the last read cycle |
| slave_rdy | input | 1 | Target ready; low requests wait states |
| bus_req | input | 1 | Another master asks for the bus |
| bus_grant | output | 1 | Bus handed over |
| addr_hi | output | 8 | High address byte |
| addr_oe | output | 1 | Drive enable for `addr_hi` |
| ad_out | output | 8 | Shared lines, outgoing value |
| ad_in | input | 8 | Shared lines, incoming value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| addr_strobe | output | 1 | High while the shared lines carry the low address |
| read_n | output | 1 | Active-low read strobe |
| write_n | output | 1 | Active-low write strobe |
| io_sel | output | 1 | 1 for I/O cycles, 0 for memory |
| cyc_stat | output | 2 | Cycle status code |
| ctl_oe | output | 1 | Drive enable for `read_n`, `write_n` and `io_sel` |

## Verification
All results are timed from the rising edge that accepts a request, counted in oscillator clocks.

- The address strobe is due in clocks 1 and 2.
- The strobe for the cycle runs from clock 3 for 2+2w clocks, where w is the number of wait T-states.
- `rsp_valid` is due in clock 2(N+w), where N is 4 for a fetch and 3 otherwise.
- The grant is due within a few clocks after that final clock.

The bench samples every output on the falling edge and counts those edges from the accepting edge. It also drives `slave_rdy` from its own count of strobe clocks, so a wait-state length it chooses reaches the block at the sampling edge. It then compares each count and position against these formulas.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_T4,
    ST_HOLD
  } tstate_t;

  localparam logic [2:0] KIND_FETCH = 3'd0;
  localparam logic [2:0] KIND_MRD   = 3'd1;
  localparam logic [2:0] KIND_MWR   = 3'd2;
  localparam logic [2:0] KIND_IORD  = 3'd3;
  localparam logic [2:0] KIND_IOWR  = 3'd4;

  typedef struct packed {
    logic fetch;
    logic io;
    logic wr;
  } cyc_attr_t;

  function automatic cyc_attr_t decode_kind(input logic [2:0] k);
    cyc_attr_t a;
    a = '0;
    case (k)
      KIND_FETCH: a.fetch = 1'b1;
      KIND_MWR:   a.wr    = 1'b1;
      KIND_IORD:  a.io    = 1'b1;
      KIND_IOWR:  begin a.io = 1'b1; a.wr = 1'b1; end
      default:    a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/bcs_tick.sv
module bcs_tick (
  input  logic clk,
  input  logic rst_n,
  output logic t_en
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign t_en = phase_q;
endmodule

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t_en,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              slave_rdy,
  input  logic              bus_req,
  input  logic [DATA_W-1:0] ad_in,
  output logic              req_ready,
  output logic              rsp_valid,
  output tstate_t           state_q,
  output cyc_attr_t         attr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  tstate_t state_d;
  logic    accept;
  logic    strobe_state;
  logic    capture;

  assign req_ready    = (state_q == ST_IDLE) && t_en && !bus_req;
  assign accept       = req_valid && req_ready;
  assign strobe_state = (state_q == ST_T2) || (state_q == ST_TW);
  assign capture      = strobe_state && slave_rdy && !attr_q.wr;
  assign rsp_valid    = t_en && (((state_q == ST_T3) && !attr_q.fetch) ||
                                 (state_q == ST_T4));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (bus_req)        state_d = ST_HOLD;
        else if (req_valid) state_d = ST_T1;
      end
      ST_T1:       state_d = ST_T2;
      ST_T2, ST_TW: state_d = slave_rdy ? ST_T3 : ST_TW;
      ST_T3:       state_d = attr_q.fetch ? ST_T4 : ST_IDLE;
      ST_T4:       state_d = ST_IDLE;
      ST_HOLD:     state_d = bus_req ? ST_HOLD : ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      attr_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (t_en) begin
      state_q <= state_d;
      if (accept) begin
        attr_q  <= decode_kind(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= ad_in;
    end
  end

  // R2: the sequence advances only on T-state boundaries
  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !t_en |=> $stable(state_q));

  // R9: a grant is entered only from an idle T-state
  p_grant_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q) != ST_HOLD) |-> $past(state_q) == ST_IDLE);

  // R4: a fourth T-state exists only for an opcode fetch
  p_t4_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_T4) |-> attr_q.fetch);

  // R8: a wait T-state follows only a low ready at the boundary
  p_wait_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TW && $past(state_q) != ST_TW) |-> !$past(slave_rdy));
endmodule

// File: rtl/bcs_pins.sv
module bcs_pins
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_t           state_q,
  input  cyc_attr_t         attr_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              addr_strobe,
  output logic              read_n,
  output logic              write_n,
  output logic              io_sel,
  output logic [1:0]        cyc_stat,
  output logic              ctl_oe,
  output logic              bus_grant
);
  logic in_cycle;

  assign in_cycle = (state_q == ST_T1) || (state_q == ST_T2) || (state_q == ST_TW) ||
                    (state_q == ST_T3) || (state_q == ST_T4);

  always_comb begin
    addr_hi     = addr_q[ADDR_W-1:DATA_W];
    addr_oe     = 1'b1;
    ad_out      = addr_q[DATA_W-1:0];
    ad_oe       = 1'b0;
    addr_strobe = 1'b0;
    read_n      = 1'b1;
    write_n     = 1'b1;
    io_sel      = 1'b0;
    cyc_stat    = 2'b00;
    ctl_oe      = 1'b1;
    bus_grant   = 1'b0;
    if (in_cycle) begin
      io_sel   = attr_q.io;
      cyc_stat = {!attr_q.wr, attr_q.wr | attr_q.fetch};
    end
    case (state_q)
      ST_T1: begin
        addr_strobe = 1'b1;
        ad_oe       = 1'b1;
      end
      ST_T2, ST_TW: begin
        read_n  = attr_q.wr;
        write_n = !attr_q.wr;
        ad_oe   = attr_q.wr;
        ad_out  = wdata_q;
      end
      ST_T3: begin
        ad_oe  = attr_q.wr;
        ad_out = wdata_q;
      end
      ST_HOLD: begin
        addr_oe   = 1'b0;
        ctl_oe    = 1'b0;
        bus_grant = 1'b1;
      end
      default: ;
    endcase
  end

  // R3: address strobe never overlaps a data strobe
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> (read_n && write_n));

  // R6: read and write strobes are never low together
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    read_n || write_n);

  // R5: the shared lines are not driven while the target drives them
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !read_n |-> !ad_oe);

  // R9: everything floats while the bus is granted
  p_float_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (!ad_oe && !ctl_oe && !addr_oe));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              slave_rdy,
  input  logic              bus_req,
  output logic              bus_grant,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_oe,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic              addr_strobe,
  output logic              read_n,
  output logic              write_n,
  output logic              io_sel,
  output logic [1:0]        cyc_stat,
  output logic              ctl_oe
);
  logic              t_en;
  tstate_t           state_q;
  cyc_attr_t         attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  bcs_tick u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .t_en  (t_en)
  );

  bcs_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .t_en      (t_en),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .slave_rdy (slave_rdy),
    .bus_req   (bus_req),
    .ad_in     (ad_in),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .state_q   (state_q),
    .attr_q    (attr_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rsp_rdata)
  );

  bcs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .attr_q      (attr_q),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .addr_hi     (addr_hi),
    .addr_oe     (addr_oe),
    .ad_out      (ad_out),
    .ad_oe       (ad_oe),
    .addr_strobe (addr_strobe),
    .read_n      (read_n),
    .write_n     (write_n),
    .io_sel      (io_sel),
    .cyc_stat    (cyc_stat),
    .ctl_oe      (ctl_oe),
    .bus_grant   (bus_grant)
  );

  // R10: the done pulse is one clock wide
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11: nothing is accepted while the bus is granted
  p_no_accept_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !req_ready);
endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        slave_rdy = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_grant;
  logic [7:0]  addr_hi;
  logic        addr_oe;
  logic [7:0]  ad_out;
  logic [7:0]  ad_in;
  logic        ad_oe;
  logic        addr_strobe;
  logic        read_n;
  logic        write_n;
  logic        io_sel;
  logic [1:0]  cyc_stat;
  logic        ctl_oe;

  logic [15:0] cur_addr = '0;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  assign ad_in = cur_addr[7:0] ^ cur_addr[15:8] ^ 8'h3C;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slave_rdy(slave_rdy),
    .bus_req(bus_req), .bus_grant(bus_grant), .addr_hi(addr_hi),
    .addr_oe(addr_oe), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
    .addr_strobe(addr_strobe), .read_n(read_n), .write_n(write_n),
    .io_sel(io_sel), .cyc_stat(cyc_stat), .ctl_oe(ctl_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_txn(input int kind, input logic [15:0] addr,
                         input logic [7:0] wd, input int w, input bit hold_mid);
    int n_t, last, ale_cnt, ale_bad, lo_bad, hi_bad, st_bad, sl, other;
    int oe_cnt, wd_bad, hl_bad, done_cnt, done_k, got_rd;
    bit isw, isio, e_s1, e_s0;
    n_t = (kind == 0) ? 4 : 3;
    last = 2 * (n_t + w);
    isw = (kind == 2) || (kind == 4);
    isio = (kind == 3) || (kind == 4);
    e_s1 = !isw;
    e_s0 = isw || (kind == 0);
    ale_cnt = 0; ale_bad = 0; lo_bad = 0; hi_bad = 0; st_bad = 0; sl = 0;
    other = 0; oe_cnt = 0; wd_bad = 0; hl_bad = 0; done_cnt = 0; done_k = 0;
    got_rd = -1;
    cur_addr = addr;
    req_kind = kind[2:0];
    req_addr = addr;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int k = 1; k <= last + 2; k++) begin
      @(negedge clk);
      if (k <= last) begin
        if (addr_strobe) begin ale_cnt++; if (k > 2) ale_bad++; end
        else if (k <= 2) ale_bad++;
        if (k <= 2 && (!ad_oe || ad_out != addr[7:0])) lo_bad++;
        if (addr_hi != addr[15:8] || !addr_oe) hi_bad++;
        if (io_sel != isio || cyc_stat != {e_s1, e_s0}) st_bad++;
        if (isw) begin if (!write_n) sl++; if (!read_n) other++; end
        else begin if (!read_n) sl++; if (!write_n) other++; end
        if (ad_oe) oe_cnt++;
        if (isw && k >= 3 && (!ad_oe || ad_out != wd)) wd_bad++;
        if (bus_grant || !ctl_oe) hl_bad++;
      end
      if (rsp_valid) begin
        done_cnt++;
        if (done_k == 0) begin done_k = k; got_rd = int'(rsp_rdata); end
      end
      slave_rdy = !(sl > 0 && sl < 2 * w + 2);
      if (hold_mid && k == 3) bus_req = 1'b1;
    end
    slave_rdy = 1'b1;
    chk("R2 R3 strobe clocks", ale_cnt, 2);
    chk("R3 strobe window", ale_bad, 0);
    chk("R3 low address", lo_bad, 0);
    chk("R3 high address", hi_bad, 0);
    chk("R7 status code", st_bad, 0);
    chk("R5 R6 R8 strobe clocks", sl, 2 * w + 2);
    chk("R6 foreign strobe", other, 0);
    if (isw) begin
      chk("R6 write data", wd_bad, 0);
      chk("R6 drive clocks", oe_cnt, last);
    end else begin
      chk("R5 bus release", oe_cnt, 2);
      chk("R5 R10 read data", got_rd, int'(addr[7:0] ^ addr[15:8] ^ 8'h3C));
    end
    chk("R4 R10 done position", done_k, last);
    chk("R10 single done", done_cnt, 1);
    chk("R9 no grant mid cycle", hl_bad, 0);
    if (hold_mid) begin
      for (int i = 0; i < 6; i++) begin
        if (bus_grant) break;
        @(negedge clk);
      end
      chk("R9 grant after cycle", int'(bus_grant), 1);
      bus_req = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 release after cycle", int'(bus_grant), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rdy_cnt, grant_seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs",
        int'({addr_strobe, read_n, write_n, ad_oe, bus_grant, rsp_valid}), 6'b011000);
    rst_n = 1'b1;
    rdy_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (req_ready) rdy_cnt++;
    end
    chk("R2 R11 idle ready rate", rdy_cnt, 3);

    for (int kind = 0; kind <= 5; kind++)
      for (int w = 0; w <= 2; w++) begin
        run_txn(kind, 16'h12F0 + 16'(kind * 16'h0111) + 16'(w), 8'hA0 + 8'(kind), w, 1'b0);
        run_txn(kind, 16'hFE01 - 16'(kind * 16'h0203), 8'h5F ^ 8'(w), w, 1'b0);
      end

    run_txn(1, 16'h4567, 8'h00, 1, 1'b1);
    run_txn(2, 16'hBEEF, 8'h77, 0, 1'b1);

    // R9 R11 grant from idle
    @(negedge clk);
    bus_req = 1'b1;
    grant_seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_grant) grant_seen = 1;
    end
    chk("R9 idle grant", grant_seen, 1);
    chk("R9 floated outputs", int'({addr_oe, ad_oe, ctl_oe}), 0);
    req_valid = 1'b1;
    rdy_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (req_ready || addr_strobe) rdy_cnt++;
    end
    chk("R11 no accept in grant", rdy_cnt, 0);
    req_valid = 1'b0;
    bus_req = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 bus taken back", int'({bus_grant, ctl_oe, addr_oe}), 3'b011);
    run_txn(0, 16'h0102, 8'h00, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule